// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the storage side of a multi-cluster system and acts as the home for a set of pages. For each page it keeps a directory entry: a flag that says whether some cluster owns the page, the identifier of that owner, and a bit vector of the clusters that hold a copy. Clusters send it three kinds of request: a plain read, a read that takes ownership, and a write-upgrade that invalidates other copies of a page the requester already holds.

For each accepted request the controller works out which clusters must act. Copy holders are invalidated. An existing owner is told to forward a copy, to write back, or both. These orders leave one per cycle in ascending cluster order and never go to the requester. The controller counts acknowledgements. When every order has been acknowledged, it updates the directory entry and sends the requester a completion. The completion says whether another owner existed and which ownership state the requester now holds.

The controller runs one transaction at a time. A request that arrives while a transaction is open is answered with a retry pulse and has no other effect. Page contents, the cache data and the bus that carries these messages are outside the block.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every directory entry is empty, and ord_valid, cpl_valid and retry_valid are low.
- R2: Request kind encoding on req_kind is 1 = read, 2 = read-for-ownership, 3 = write-upgrade. A request with kind 0 is ignored: no order, completion or retry follows, and the directory is unchanged.
- R3: A read of a page with no owner other than the requester sends no orders. Its completion carries owner_existed 0 and grant code 1 (exclusive clean), and the requester becomes the owner.
- R4: A read of a page owned by another cluster sends exactly one order to that owner, with kind code 1 (forward a copy to the requester). Its completion carries owner_existed 1 and grant code 0 (shared). The owner is unchanged and the requester is added as a sharer.
- R5: A read-for-ownership sends kind code 0 (invalidate) to every copy holder other than the requester and the owner. An owner other than the requester receives kind code 2 (forward a copy, write back, invalidate). With no such owner the home supplies the copy and no forward is ordered. The completion carries grant code 2 (exclusive dirty) and owner_existed set exactly when such an owner existed.
- R6: A write-upgrade sends kind code 0 to every copy holder other than the requester and the owner. An owner other than the requester receives kind code 3 (write back and invalidate). The completion carries grant code 2, and owner_existed is set exactly when such an owner existed.
- R7: A completion is raised only after as many ack_valid pulses as orders were issued. The earliest is one cycle after the clock edge that takes the final acknowledgement, and with no orders it is the second cycle after the accepting edge.
- R8: After a read-for-ownership or a write-upgrade completes, the requester is the only copy holder and the owner of the page. Later requests to that page show this in their orders.
- R9: A request with a nonzero kind that arrives while a transaction is open gets a retry pulse in the next cycle, carrying the requester's cluster identifier. It changes neither the directory nor the open transaction.
- R10: No order is ever addressed to the requester, and the orders of one transaction leave on consecutive order cycles in strictly ascending cluster order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Request kind (0 none, 1 read, 2 read-for-ownership, 3 write-upgrade) |
| req_cluster | input | CID_W | Requesting cluster |
| req_page | input | PG_W | Page addressed |
| ord_valid | output | 1 | An order is presented this cycle |
| ord_kind | output | 2 | 0 invalidate, 1 forward, 2 forward plus write back, 3 write back |
| ord_cluster | output | CID_W | Cluster that must carry out the order |
| ord_requester | output | CID_W | Cluster that receives any forwarded copy |
| ord_page | output | PG_W | Page of the order |
| ack_valid | input | 1 | One acknowledgement of an issued order |
| cpl_valid | output | 1 | Completion pulse |
| cpl_cluster | output | CID_W | Requester being completed |
| cpl_page | output | PG_W | Page being completed |
| cpl_owner_existed | output | 1 | Another cluster owned the page at lookup |
| cpl_grant | output | 2 | 0 shared, 1 exclusive clean, 2 exclusive dirty |
| retry_valid | output | 1 | Retry pulse for a request that arrived while busy |
| retry_cluster | output | CID_W | Cluster told to retry |

## Verification
A corrupted directory entry cannot be seen directly. It shows up at the next request to the same page: an order goes to the wrong cluster or with the wrong kind, an order is missing or extra, or owner_existed and the grant code are wrong. The bench therefore keeps its own directory model and sends follow-up requests to the same page right after each transfer of ownership, so a bad update is exposed one transaction later. A wrong pending count shows up within a few cycles of the final acknowledgement, as a completion that comes before all acknowledgements or never comes. Acknowledgements are held back to widen that window.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_READ = 2'd1,
        REQ_RFO  = 2'd2,
        REQ_WUP  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ORD_INV    = 2'd0,
        ORD_FWD    = 2'd1,
        ORD_FWD_WB = 2'd2,
        ORD_WB     = 2'd3
    } ord_kind_e;

    typedef enum logic [1:0] {
        GR_SHARED      = 2'd0,
        GR_EXCL_CLEAN  = 2'd1,
        GR_EXCL_DIRTY  = 2'd2
    } grant_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/hdc_order_plan.sv
module hdc_order_plan
    import hdc_pkg::*;
#(
    parameter int N_CLUSTERS = 4,
    parameter int CID_W      = 2,
    parameter int CNT_W      = 3
) (
    input  logic [1:0]                  kind,
    input  logic [CID_W-1:0]            rid,
    input  logic                        own_vld,
    input  logic [CID_W-1:0]            own_id,
    input  logic [N_CLUSTERS-1:0]       sharers,
    output logic [N_CLUSTERS-1:0]       plan_mask,
    output logic [N_CLUSTERS-1:0][1:0]  plan_kinds,
    output logic [CNT_W-1:0]            plan_cnt,
    output logic [CID_W-1:0]            new_own,
    output logic [N_CLUSTERS-1:0]       new_sharers,
    output logic [1:0]                  grant,
    output logic                        owner_other
);
    logic                  is_read;
    logic [N_CLUSTERS-1:0] rid_onehot;

    assign is_read     = (kind == REQ_READ);
    assign owner_other = own_vld && (own_id != rid);
    assign rid_onehot  = N_CLUSTERS'(1) << rid;

    for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cl
        logic is_req, is_own, is_shr;
        assign is_req = (rid == CID_W'(c));
        assign is_own = owner_other && (own_id == CID_W'(c));
        assign is_shr = sharers[c] && !is_req;
        assign plan_mask[c]  = is_read ? is_own : (is_own || is_shr);
        assign plan_kinds[c] = is_read ? ORD_FWD
                             : !is_own ? ORD_INV
                             : (kind == REQ_RFO) ? ORD_FWD_WB : ORD_WB;
    end

    always_comb begin
        plan_cnt = '0;
        for (int i = 0; i < N_CLUSTERS; i++) begin
            plan_cnt = plan_cnt + CNT_W'(plan_mask[i]);
        end
    end

    always_comb begin
        if (is_read) begin
            new_own     = owner_other ? own_id : rid;
            new_sharers = sharers | rid_onehot;
            grant       = owner_other ? GR_SHARED : GR_EXCL_CLEAN;
        end else begin
            new_own     = rid;
            new_sharers = rid_onehot;
            grant       = GR_EXCL_DIRTY;
        end
    end
endmodule

// File: rtl/hdc_pick_lowest.sv
module hdc_pick_lowest #(
    parameter int N_CLUSTERS = 4,
    parameter int CID_W      = 2
) (
    input  logic [N_CLUSTERS-1:0] mask,
    output logic                  found,
    output logic [CID_W-1:0]      idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_CLUSTERS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = CID_W'(i);
            end
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import hdc_pkg::*;
#(
    parameter int N_CLUSTERS = 4,
    parameter int N_PAGES    = 8,
    localparam int CID_W = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
    localparam int PG_W  = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [CID_W-1:0] req_cluster,
    input  logic [PG_W-1:0]  req_page,
    output logic             ord_valid,
    output logic [1:0]       ord_kind,
    output logic [CID_W-1:0] ord_cluster,
    output logic [CID_W-1:0] ord_requester,
    output logic [PG_W-1:0]  ord_page,
    input  logic             ack_valid,
    output logic             cpl_valid,
    output logic [CID_W-1:0] cpl_cluster,
    output logic [PG_W-1:0]  cpl_page,
    output logic             cpl_owner_existed,
    output logic [1:0]       cpl_grant,
    output logic             retry_valid,
    output logic [CID_W-1:0] retry_cluster
);
    localparam int CNT_W = $clog2(N_CLUSTERS + 1);

    typedef struct packed {
        eng_state_e                          st;
        logic [CID_W-1:0]                    t_rid;
        logic [PG_W-1:0]                     t_page;
        logic [N_CLUSTERS-1:0]               t_mask;
        logic [N_CLUSTERS-1:0][1:0]          t_kinds;
        logic [CNT_W-1:0]                    t_pend;
        logic [CID_W-1:0]                    t_new_own;
        logic [N_CLUSTERS-1:0]               t_new_sh;
        logic [1:0]                          t_grant;
        logic                                t_existed;
        logic                                cpl_v;
        logic                                retry_v;
        logic [CID_W-1:0]                    retry_cid;
        logic [N_PAGES-1:0]                  dir_ov;
        logic [N_PAGES-1:0][CID_W-1:0]       dir_own;
        logic [N_PAGES-1:0][N_CLUSTERS-1:0]  dir_sh;
    } ctrl_state_t;

    ctrl_state_t q, d;

    // plan for the incoming request, from the addressed directory entry
    logic [N_CLUSTERS-1:0]      plan_mask;
    logic [N_CLUSTERS-1:0][1:0] plan_kinds;
    logic [CNT_W-1:0]           plan_cnt;
    logic [CID_W-1:0]           plan_new_own;
    logic [N_CLUSTERS-1:0]      plan_new_sh;
    logic [1:0]                 plan_grant;
    logic                       plan_existed;

    hdc_order_plan #(
        .N_CLUSTERS (N_CLUSTERS),
        .CID_W      (CID_W),
        .CNT_W      (CNT_W)
    ) i_plan (
        .kind        (req_kind),
        .rid         (req_cluster),
        .own_vld     (q.dir_ov[req_page]),
        .own_id      (q.dir_own[req_page]),
        .sharers     (q.dir_sh[req_page]),
        .plan_mask   (plan_mask),
        .plan_kinds  (plan_kinds),
        .plan_cnt    (plan_cnt),
        .new_own     (plan_new_own),
        .new_sharers (plan_new_sh),
        .grant       (plan_grant),
        .owner_other (plan_existed)
    );

    // next order to issue: lowest pending cluster
    logic             pick_found;
    logic [CID_W-1:0] pick_idx;

    hdc_pick_lowest #(
        .N_CLUSTERS (N_CLUSTERS),
        .CID_W      (CID_W)
    ) i_pick (
        .mask  (q.t_mask),
        .found (pick_found),
        .idx   (pick_idx)
    );

    logic req_live;
    assign req_live = req_valid && (req_kind != REQ_NONE);

    always_comb begin
        d         = q;
        d.cpl_v   = 1'b0;
        d.retry_v = 1'b0;
        unique case (q.st)
            ENG_IDLE: begin
                if (req_live) begin
                    d.st        = ENG_RUN;
                    d.t_rid     = req_cluster;
                    d.t_page    = req_page;
                    d.t_mask    = plan_mask;
                    d.t_kinds   = plan_kinds;
                    d.t_pend    = plan_cnt;
                    d.t_new_own = plan_new_own;
                    d.t_new_sh  = plan_new_sh;
                    d.t_grant   = plan_grant;
                    d.t_existed = plan_existed;
                end
            end
            ENG_RUN: begin
                if (req_live) begin
                    d.retry_v   = 1'b1;
                    d.retry_cid = req_cluster;
                end
                if (pick_found) begin
                    d.t_mask[pick_idx] = 1'b0;
                end
                if (ack_valid && (q.t_pend != '0)) begin
                    d.t_pend = q.t_pend - CNT_W'(1);
                end
                if (!pick_found && (q.t_pend == '0)) begin
                    d.st                = ENG_IDLE;
                    d.cpl_v             = 1'b1;
                    d.dir_ov[q.t_page]  = 1'b1;
                    d.dir_own[q.t_page] = q.t_new_own;
                    d.dir_sh[q.t_page]  = q.t_new_sh;
                end
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ord_valid         = (q.st == ENG_RUN) && pick_found;
    assign ord_kind          = q.t_kinds[pick_idx];
    assign ord_cluster       = pick_idx;
    assign ord_requester     = q.t_rid;
    assign ord_page          = q.t_page;
    assign cpl_valid         = q.cpl_v;
    assign cpl_cluster       = q.t_rid;
    assign cpl_page          = q.t_page;
    assign cpl_owner_existed = q.t_existed;
    assign cpl_grant         = q.t_grant;
    assign retry_valid       = q.retry_v;
    assign retry_cluster     = q.retry_cid;
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker #(
    parameter int N_CLUSTERS = 4,
    parameter int N_PAGES    = 8,
    localparam int CID_W = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
    localparam int CNT_W = $clog2(N_CLUSTERS + 1) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [CID_W-1:0] req_cluster,
    input logic             ord_valid,
    input logic [CID_W-1:0] ord_cluster,
    input logic [CID_W-1:0] ord_requester,
    input logic             ack_valid,
    input logic             cpl_valid,
    input logic             cpl_owner_existed,
    input logic [1:0]       cpl_grant,
    input logic             retry_valid,
    input logic [CID_W-1:0] retry_cluster
);
    // orders seen at the port minus acknowledgements received
    logic [CNT_W-1:0] outst_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else if (ord_valid && !ack_valid) begin
            outst_q <= outst_q + CNT_W'(1);
        end else if (!ord_valid && ack_valid && (outst_q != '0)) begin
            outst_q <= outst_q - CNT_W'(1);
        end
    end

    assert_no_self_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ord_valid |-> (ord_cluster != ord_requester));

    assert_ascending_orders_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_valid && $past(ord_valid)) |-> (ord_cluster > $past(ord_cluster)));

    assert_cpl_after_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (outst_q == '0));

    assert_retry_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> ($past(req_valid) && ($past(req_cluster) == retry_cluster)));

    assert_unowned_not_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_owner_existed) |-> (cpl_grant != 2'd0));
endmodule

bind home_dir_ctrl hdc_checker #(
    .N_CLUSTERS (N_CLUSTERS),
    .N_PAGES    (N_PAGES)
) i_hdc_checker (.*);

// File: tb/test_home_dir_ctrl.sv
module test_home_dir_ctrl;
    localparam int NC = 4;
    localparam int NP = 8;
    localparam int CW = 2;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [CW-1:0] req_cluster = '0;
    logic [PW-1:0] req_page = '0;
    logic          ord_valid;
    logic [1:0]    ord_kind;
    logic [CW-1:0] ord_cluster;
    logic [CW-1:0] ord_requester;
    logic [PW-1:0] ord_page;
    logic          ack_valid = 1'b0;
    logic          cpl_valid;
    logic [CW-1:0] cpl_cluster;
    logic [PW-1:0] cpl_page;
    logic          cpl_owner_existed;
    logic [1:0]    cpl_grant;
    logic          retry_valid;
    logic [CW-1:0] retry_cluster;

    int checks = 0;
    int fails  = 0;

    // bench-side directory model
    bit          m_ov  [NP];
    int          m_own [NP];
    bit [NC-1:0] m_sh  [NP];

    always #4 clk = ~clk;

    home_dir_ctrl #(.N_CLUSTERS(NC), .N_PAGES(NP)) i_home_dir_ctrl (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // issue one request, collect orders/acks, check completion against the model
    task automatic do_req(input int kind, input int rid, input int pg, input int hold,
                          input bit intr, input int icid, input int ipg, input string req);
        bit          own_other;
        bit [NC-1:0] emask;
        int          ek [NC];
        int          egrant;
        int          owed = 0;
        int          last_ord = -100;
        int          seen = 0;
        int          nexp;
        bit          got_cpl = 0;

        own_other = m_ov[pg] && (m_own[pg] != rid);
        for (int c = 0; c < NC; c++) begin
            bit is_own = own_other && (m_own[pg] == c);
            bit is_shr = m_sh[pg][c] && (c != rid);
            if (kind == 1) begin
                emask[c] = is_own;
                ek[c]    = 1;
            end else begin
                emask[c] = is_own || is_shr;
                ek[c]    = !is_own ? 0 : (kind == 2 ? 2 : 3);
            end
        end
        egrant = (kind == 1) ? (own_other ? 0 : 1) : 2;
        nexp   = $countones(emask);

        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_cluster = CW'(rid); req_page = PW'(pg);
        for (int cyc = 0; cyc < 80 && !got_cpl; cyc++) begin
            @(negedge clk);
            ack_valid = 1'b0;
            if (cyc == 0 && intr) begin
                req_valid = 1'b1; req_kind = 2'd2; req_cluster = CW'(icid); req_page = PW'(ipg);
            end else begin
                req_valid = 1'b0;
            end
            if (cyc == 1 && intr) begin
                check(retry_valid == 1'b1, "R9", "retry pulse", int'(retry_valid), 1);
                check(retry_cluster == CW'(icid), "R9", "retry cluster", int'(retry_cluster), icid);
            end
            if (ord_valid) begin
                int want = -1;
                for (int c = NC - 1; c >= 0; c--) if (emask[c]) want = c;
                check(want >= 0, "R10", "unexpected extra order", int'(ord_cluster), -1);
                if (want >= 0) begin
                    check(int'(ord_cluster) == want, "R10", "order cluster ascending",
                          int'(ord_cluster), want);
                    check(int'(ord_kind) == ek[want], req, "order kind", int'(ord_kind), ek[want]);
                    emask[want] = 1'b0;
                end
                check(int'(ord_requester) == rid && int'(ord_page) == pg, "R10",
                      "order requester", int'(ord_requester), rid);
                seen++; owed++; last_ord = cyc;
                if (hold == 0) begin
                    ack_valid = 1'b1; owed--;
                end
            end else if (owed > 0 && (cyc - last_ord) >= hold) begin
                ack_valid = 1'b1; owed--;
            end
            if (cpl_valid) begin
                got_cpl = 1;
                ack_valid = 1'b0;
                check(owed == 0, "R7", "completion before all acks", owed, 0);
                check(seen == nexp, req, "order count", seen, nexp);
                check(int'(cpl_cluster) == rid && int'(cpl_page) == pg, req,
                      "completion target", int'(cpl_cluster), rid);
                check(cpl_owner_existed == own_other, req, "owner existed",
                      int'(cpl_owner_existed), int'(own_other));
                check(int'(cpl_grant) == egrant, req, "grant", int'(cpl_grant), egrant);
            end
        end
        ack_valid = 1'b0;
        check(got_cpl, req, "completion arrived", int'(got_cpl), 1);
        if (kind == 1) begin
            m_sh[pg][rid] = 1'b1;
            if (!own_other) begin m_ov[pg] = 1; m_own[pg] = rid; end
        end else begin
            m_ov[pg] = 1; m_own[pg] = rid; m_sh[pg] = '0; m_sh[pg][rid] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(ord_valid == 1'b0, "R1", "ord_valid after reset", int'(ord_valid), 0);
        check(cpl_valid == 1'b0, "R1", "cpl_valid after reset", int'(cpl_valid), 0);
        check(retry_valid == 1'b0, "R1", "retry_valid after reset", int'(retry_valid), 0);
    endtask

    task automatic t_read_unowned;       // R1 empty directory, R3 home supplies
        do_req(1, 1, 0, 0, 0, 0, 0, "R3");
    endtask

    task automatic t_read_owned;         // R4 forward from owner
        do_req(1, 2, 0, 0, 0, 0, 0, "R4");
        do_req(1, 3, 0, 2, 0, 0, 0, "R4");
    endtask

    task automatic t_rfo_with_sharers;   // R5 fwd+wb to owner, inval to sharers, held acks R7
        do_req(2, 0, 0, 3, 0, 0, 0, "R5");
        do_req(1, 3, 0, 0, 0, 0, 0, "R8");   // shows c0 alone owns page 0
    endtask

    task automatic t_wup_from_sharer;    // R6 write back from owner
        do_req(3, 3, 0, 1, 0, 0, 0, "R6");
        do_req(1, 1, 0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_rfo_unowned;        // R5 with no owner
        do_req(2, 2, 1, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_retry_busy;         // R9 retry while open, page 2 untouched
        do_req(2, 1, 1, 5, 1, 3, 2, "R5");
        do_req(1, 0, 2, 0, 0, 0, 0, "R9");
    endtask

    task automatic t_wup_self_owner;     // R6 owner upgrades, requester excluded R10
        do_req(1, 0, 1, 0, 0, 0, 0, "R4");
        do_req(3, 1, 1, 2, 0, 0, 0, "R6");
    endtask

    task automatic t_ignore_kind0;       // R2 kind 0 has no effect
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_cluster = 2'd2; req_page = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!ord_valid && !cpl_valid && !retry_valid, "R2", "activity after kind 0",
                  int'({ord_valid, cpl_valid, retry_valid}), 0);
            @(negedge clk);
        end
        do_req(1, 1, 3, 0, 0, 0, 0, "R2");
    endtask

    task automatic t_full_fanout;        // R10 ascending orders to all others
        do_req(1, 0, 4, 0, 0, 0, 0, "R3");
        do_req(1, 1, 4, 0, 0, 0, 0, "R4");
        do_req(1, 2, 4, 0, 0, 0, 0, "R4");
        do_req(1, 3, 4, 0, 0, 0, 0, "R4");
        do_req(3, 2, 4, 0, 0, 0, 0, "R6");
        do_req(2, 3, 4, 1, 0, 0, 0, "R5");
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin m_ov[p] = 0; m_own[p] = 0; m_sh[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_unowned();
        t_read_owned();
        t_rfo_with_sharers();
        t_wup_from_sharer();
        t_rfo_unowned();
        t_retry_busy();
        t_wup_self_owner();
        t_ignore_kind0();
        t_full_fanout();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule